// File: doc/BRIEF.md
# Socket Power-Good and Reset Sequencer

This block brings a processor socket out of power-down and keeps it in a safe state. It takes three board indications: supplies stable, reference clock stable, and an active-low socket-occupied input. From these it drives the power-good output, the active-low processor reset and the active-low test-port reset. A single cycle counter enforces every reset width and every gap between resets. The counter scales from a cycles-per-millisecond parameter, so a bench can run with small values.

A reset request input starts a warm reset. While the request is held, the reset is stretched, up to a ceiling. A request that comes too soon after the last reset was released is held back until the required gap has passed. A thermal-trip input sampled while the processor is running is latched. The latch drops power-good and raises a supply-removal request, and only a reset request clears it. A sticky flag reports a reset that had to be cut off at its maximum width.

Top module: `sock_pwr_seq`

## Requirements
- R1: After the asynchronous reset, all of these outputs are low: `pwrGood`, `cpuResetN`, `tapResetN`, `supplyOff` and `timingErr`.
- R2: Power-up begins only when `suppliesOk` and `clockOk` are both 1 and `sockOccN` is 0. Otherwise `pwrGood` stays 0.
- R3: `pwrGood` only ever rises while `cpuResetN` is 0.
- R4: On power-up, `pwrGood` rises one cycle after the enabling inputs are sampled. `cpuResetN` then stays 0 for exactly MIN_RST = CYC_PER_MS*RST_MIN_MS cycles (request low) before it rises.
- R5: `tapResetN` is 0 from power-down through the whole power-on reset and rises together with `cpuResetN`. It stays 1 during a warm reset.
- R6: A warm reset keeps `cpuResetN` at 0 for at least MIN_RST cycles, and for as long as `resetReq` stays 1. It is released after MAX_RST = CYC_PER_MS*RST_MAX_MS cycles at most. Release at that limit while the request is still 1 sets `timingErr`, which then stays 1 until the asynchronous reset.
- R7: After `cpuResetN` rises, it stays 1 for at least MIN_GAP = CYC_PER_MS*GAP_MIN_MS cycles. A one-cycle request made in the first deasserted cycle is deferred, and reset asserts after exactly MIN_GAP deasserted cycles.
- R8: When `suppliesOk` or `clockOk` drops, `pwrGood` and `cpuResetN` are 0 on the next cycle, whether the reset is held or running.
- R9: `thermTrip` sampled with reset released latches a trip state. In that state `pwrGood` is 0, `cpuResetN` is 0 and `supplyOff` is 1, even after `thermTrip` drops. A `resetReq` clears the latch and power-up then repeats. A trip still present after the next release latches again.
- R10: `thermTrip` has no effect while `cpuResetN` is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer itself |
| suppliesOk | input | 1 | All socket supplies within specification |
| clockOk | input | 1 | Reference clock within specification |
| sockOccN | input | 1 | 0 when a processor is seated |
| resetReq | input | 1 | Software or button reset request, level |
| thermTrip | input | 1 | Thermal-trip indication from the processor |
| pwrGood | output | 1 | Power-good to the processor |
| cpuResetN | output | 1 | Active-low processor reset |
| tapResetN | output | 1 | Active-low test-port reset |
| supplyOff | output | 1 | Request to remove the socket supplies after a thermal trip |
| timingErr | output | 1 | Sticky flag: a reset hit its maximum width |

## Verification
The bench measures the reset width to the exact cycle, both on power-up and on warm reset. A counter that was off by one would give a pulse one cycle short or long. The bench also places a request in the first deasserted cycle: a design that ignored the gap would reset at once, and one that dropped the request would never reset. It holds a request past the maximum width, which catches a design that stretches the reset forever or fails to set the flag. Finally, it raises a trip during the reset hold and again after release, which separates a design that trips too early from one that forgets to latch again.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_HOLD = 2'd1,
    ST_RUN  = 2'd2,
    ST_TRIP = 2'd3
  } seqState_e;

  typedef struct packed {
    logic cntClr;
    logic pendSet;
    logic pendClr;
    logic errSet;
  } seqStrobe_t;

endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int MIN_ASSERT = 8,
  parameter int MAX_ASSERT = 80,
  parameter int MIN_GAP    = 8,
  parameter int LIMIT      = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seqStrobe_t       strobe,
  output logic [CNT_W-1:0] cntVal,
  output logic             holdMinDone,
  output logic             holdMaxHit,
  output logic             gapDone,
  output logic             pending,
  output logic             timingErr
);

  localparam logic [CNT_W-1:0] MinLast = CNT_W'(MIN_ASSERT - 1);
  localparam logic [CNT_W-1:0] MaxLast = CNT_W'(MAX_ASSERT - 1);
  localparam logic [CNT_W-1:0] GapLast = CNT_W'(MIN_GAP - 1);
  localparam logic [CNT_W-1:0] SatVal  = CNT_W'(LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntVal <= '0;
    end else if (strobe.cntClr) begin
      cntVal <= '0;
    end else if (cntVal != SatVal) begin
      cntVal <= cntVal + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else if (strobe.pendClr) begin
      pending <= 1'b0;
    end else if (strobe.pendSet) begin
      pending <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timingErr <= 1'b0;
    end else if (strobe.errSet) begin
      timingErr <= 1'b1;
    end
  end

  assign holdMinDone = (cntVal >= MinLast);
  assign holdMaxHit  = (cntVal >= MaxLast);
  assign gapDone     = (cntVal >= GapLast);

  // R6: error flag never clears once set
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    timingErr |=> timingErr);

  // R7: a deferred request is remembered until consumed
  a_r7_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !strobe.pendClr) |=> pending);

endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int MIN_ASSERT = 8,
  parameter int MAX_ASSERT = 80,
  parameter int MIN_GAP    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             suppliesOk,
  input  logic             clockOk,
  input  logic             sockOccN,
  input  logic             resetReq,
  input  logic             thermTrip,
  input  logic             holdMinDone,
  input  logic             holdMaxHit,
  input  logic             gapDone,
  input  logic             pending,
  input  logic [CNT_W-1:0] cntVal,
  output seqStrobe_t       strobe,
  output logic             pwrGood,
  output logic             cpuResetN,
  output logic             tapResetN,
  output logic             supplyOff
);

  seqState_e state;
  seqState_e nextState;
  logic      coldFlag;
  logic      pwrOk;

  assign pwrOk = suppliesOk && clockOk;

  always_comb begin
    nextState      = state;
    strobe         = '0;
    unique case (state)
      ST_OFF: begin
        if (pwrOk && !sockOccN) nextState = ST_HOLD;
      end
      ST_HOLD: begin
        if (!pwrOk) begin
          nextState = ST_OFF;
        end else if (holdMinDone && (!resetReq || holdMaxHit)) begin
          nextState     = ST_RUN;
          strobe.errSet = resetReq;
        end
      end
      ST_RUN: begin
        if (!pwrOk) begin
          nextState = ST_OFF;
        end else if (thermTrip) begin
          nextState = ST_TRIP;
        end else if (gapDone && (resetReq || pending)) begin
          nextState = ST_HOLD;
        end else if (resetReq) begin
          strobe.pendSet = 1'b1;
        end
      end
      ST_TRIP: begin
        if (resetReq) nextState = ST_OFF;
      end
      default: nextState = ST_OFF;
    endcase
    strobe.cntClr  = (nextState != state);
    strobe.pendClr = (state == ST_RUN) && (nextState != ST_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_OFF;
      coldFlag <= 1'b1;
    end else begin
      state <= nextState;
      if (state == ST_OFF || state == ST_TRIP) begin
        coldFlag <= 1'b1;
      end else if (state == ST_RUN) begin
        coldFlag <= 1'b0;
      end
    end
  end

  assign pwrGood   = (state == ST_HOLD) || (state == ST_RUN);
  assign cpuResetN = (state == ST_RUN);
  assign tapResetN = (state == ST_RUN) || (state == ST_HOLD && !coldFlag);
  assign supplyOff = (state == ST_TRIP);

  // R3: power-good only rises under reset
  a_r3_pg_under_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwrGood) |-> !cpuResetN);

  // R4: reset released only after the minimum width
  a_r4_min_width: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && nextState == ST_RUN) |-> (cntVal >= CNT_W'(MIN_ASSERT - 1)));

  // R6: reset never held beyond the maximum width
  a_r6_max_width: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |-> (cntVal <= CNT_W'(MAX_ASSERT - 1)));

  // R7: gap respected before re-entering reset
  a_r7_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && nextState == ST_HOLD) |-> (cntVal >= CNT_W'(MIN_GAP - 1)));

  // R8: supply or clock loss drops power-good next cycle
  a_r8_power_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrGood && !pwrOk) |=> !pwrGood);

  // R9: trip state held until a reset request
  a_r9_trip_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (supplyOff && !resetReq) |=> (supplyOff && !pwrGood));

endmodule

// File: rtl/sock_pwr_seq.sv
module sock_pwr_seq
  import seq_pkg::*;
#(
  parameter int CYC_PER_MS = 100000,
  parameter int RST_MIN_MS = 1,
  parameter int RST_MAX_MS = 10,
  parameter int GAP_MIN_MS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic suppliesOk,
  input  logic clockOk,
  input  logic sockOccN,
  input  logic resetReq,
  input  logic thermTrip,
  output logic pwrGood,
  output logic cpuResetN,
  output logic tapResetN,
  output logic supplyOff,
  output logic timingErr
);

  localparam int MinRst = CYC_PER_MS * RST_MIN_MS;
  localparam int MaxRst = CYC_PER_MS * RST_MAX_MS;
  localparam int MinGap = CYC_PER_MS * GAP_MIN_MS;
  localparam int Limit  = (MaxRst > MinGap) ? MaxRst : MinGap;
  localparam int CntW   = $clog2(Limit + 1);

  seqStrobe_t      strobe;
  logic [CntW-1:0] cntVal;
  logic            holdMinDone;
  logic            holdMaxHit;
  logic            gapDone;
  logic            pending;

  seq_control #(
    .CNT_W(CntW), .MIN_ASSERT(MinRst), .MAX_ASSERT(MaxRst), .MIN_GAP(MinGap)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .suppliesOk(suppliesOk), .clockOk(clockOk), .sockOccN(sockOccN),
    .resetReq(resetReq), .thermTrip(thermTrip),
    .holdMinDone(holdMinDone), .holdMaxHit(holdMaxHit), .gapDone(gapDone),
    .pending(pending), .cntVal(cntVal), .strobe(strobe),
    .pwrGood(pwrGood), .cpuResetN(cpuResetN), .tapResetN(tapResetN),
    .supplyOff(supplyOff)
  );

  seq_datapath #(
    .CNT_W(CntW), .MIN_ASSERT(MinRst), .MAX_ASSERT(MaxRst), .MIN_GAP(MinGap),
    .LIMIT(Limit)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .cntVal(cntVal),
    .holdMinDone(holdMinDone), .holdMaxHit(holdMaxHit), .gapDone(gapDone),
    .pending(pending), .timingErr(timingErr)
  );

endmodule

// File: tb/tb_sock_pwr_seq.sv
`timescale 1ns/1ps
module tb_sock_pwr_seq;

  localparam int CPM  = 8;
  localparam int MINA = CPM;
  localparam int MAXA = CPM * 10;
  localparam int MING = CPM;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic suppliesOk = 1'b0, clockOk = 1'b0, sockOccN = 1'b1;
  logic resetReq = 1'b0, thermTrip = 1'b0;
  logic pwrGood, cpuResetN, tapResetN, supplyOff, timingErr;

  int checkCount = 0;
  int failCount  = 0;

  always #5 clk = ~clk;

  sock_pwr_seq #(.CYC_PER_MS(CPM)) dut (
    .clk(clk), .rst_n(rst_n), .suppliesOk(suppliesOk), .clockOk(clockOk),
    .sockOccN(sockOccN), .resetReq(resetReq), .thermTrip(thermTrip),
    .pwrGood(pwrGood), .cpuResetN(cpuResetN), .tapResetN(tapResetN),
    .supplyOff(supplyOff), .timingErr(timingErr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quietBoot();
    suppliesOk = 1'b1; clockOk = 1'b1; sockOccN = 1'b0;
    step(MINA + 1);
  endtask

  task automatic t_reset();
    step(2);
    chk(pwrGood == 0 && cpuResetN == 0, "R1 pg/rst", {pwrGood, cpuResetN}, 0);
    chk(tapResetN == 0 && supplyOff == 0 && timingErr == 0, "R1 tap/off/err",
        {tapResetN, supplyOff, timingErr}, 0);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_blocked();
    suppliesOk = 1'b1; clockOk = 1'b1; sockOccN = 1'b1;
    step(5);
    chk(pwrGood == 0, "R2 empty socket", pwrGood, 0);
    sockOccN = 1'b0; clockOk = 1'b0;
    step(5);
    chk(pwrGood == 0, "R2 clock not ok", pwrGood, 0);
  endtask

  task automatic t_cold();
    clockOk = 1'b1;
    step(1);
    chk(pwrGood == 1 && cpuResetN == 0, "R4 pg rises under reset", {pwrGood, cpuResetN}, 2);
    chk(tapResetN == 0, "R5 tap low in cold hold", tapResetN, 0);
    step(MINA - 1);
    chk(cpuResetN == 0, "R4 still held at MIN_RST", cpuResetN, 0);
    step(1);
    chk(cpuResetN == 1, "R4 released after MIN_RST", cpuResetN, 1);
    chk(tapResetN == 1, "R5 tap released with cpu", tapResetN, 1);
  endtask

  task automatic t_gap();
    resetReq = 1'b1;
    step(1);
    resetReq = 1'b0;
    step(MING - 2);
    chk(cpuResetN == 1, "R7 request deferred", cpuResetN, 1);
    step(1);
    chk(cpuResetN == 0, "R7 deferred reset at gap end", cpuResetN, 0);
    chk(tapResetN == 1, "R5 tap high in warm reset", tapResetN, 1);
    step(MINA - 1);
    chk(cpuResetN == 0, "R6 warm min width", cpuResetN, 0);
    step(1);
    chk(cpuResetN == 1, "R6 warm release", cpuResetN, 1);
  endtask

  task automatic t_extend();
    step(MING);
    resetReq = 1'b1;
    step(1);
    chk(cpuResetN == 0, "R6 warm entry", cpuResetN, 0);
    step(2 * MINA - 1);
    chk(cpuResetN == 0, "R6 stretched while held", cpuResetN, 0);
    resetReq = 1'b0;
    step(1);
    chk(cpuResetN == 1 && timingErr == 0, "R6 release after drop", {cpuResetN, timingErr}, 2);
  endtask

  task automatic t_max();
    step(MING);
    resetReq = 1'b1;
    step(1);
    step(MAXA - 1);
    chk(cpuResetN == 0 && timingErr == 0, "R6 held to MAX_RST", {cpuResetN, timingErr}, 0);
    step(1);
    resetReq = 1'b0;
    chk(cpuResetN == 1, "R6 forced release at MAX_RST", cpuResetN, 1);
    chk(timingErr == 1, "R6 error set", timingErr, 1);
    step(5);
    chk(timingErr == 1, "R6 error sticky", timingErr, 1);
  endtask

  task automatic t_loss();
    suppliesOk = 1'b0;
    step(1);
    chk(pwrGood == 0 && cpuResetN == 0, "R8 supply loss in run", {pwrGood, cpuResetN}, 0);
    chk(tapResetN == 0, "R5 tap low after loss", tapResetN, 0);
    suppliesOk = 1'b1;
    step(4);
    clockOk = 1'b0;
    step(1);
    chk(pwrGood == 0, "R8 clock loss in hold", pwrGood, 0);
    clockOk = 1'b1;
    quietBoot();
    chk(cpuResetN == 1, "R8 reboot after loss", cpuResetN, 1);
  endtask

  task automatic t_thermal();
    thermTrip = 1'b1;
    step(1);
    chk(supplyOff == 1 && pwrGood == 0 && cpuResetN == 0, "R9 trip latched",
        {supplyOff, pwrGood, cpuResetN}, 4);
    thermTrip = 1'b0;
    step(4);
    chk(supplyOff == 1 && pwrGood == 0, "R9 trip held after input drops", {supplyOff, pwrGood}, 2);
    resetReq = 1'b1;
    step(1);
    resetReq = 1'b0;
    chk(supplyOff == 0, "R9 cleared by request", supplyOff, 0);
    thermTrip = 1'b1;
    step(1);
    chk(pwrGood == 1 && supplyOff == 0, "R10 trip ignored in hold", {pwrGood, supplyOff}, 2);
    step(MINA - 1);
    chk(supplyOff == 0 && cpuResetN == 0, "R10 still holding", {supplyOff, cpuResetN}, 0);
    step(1);
    chk(cpuResetN == 1, "R9 released with trip present", cpuResetN, 1);
    step(1);
    chk(supplyOff == 1, "R9 trip relatched", supplyOff, 1);
    thermTrip = 1'b0;
  endtask

  initial begin
    t_reset();
    t_blocked();
    t_cold();
    t_gap();
    t_extend();
    t_max();
    t_loss();
    t_thermal();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    #200000;
    checkCount++;
    failCount++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule